// File: doc/BRIEF.md
# SPI Receive Status Flags

This block keeps the receive-side status of a serial peripheral: the receive word buffer, a full flag, an overrun flag and a bit-error flag. The flags feed an interrupt mapper with two output lines. The shifter delivers single-cycle event pulses: a word has arrived, or a bit error has occurred. Software reaches the flags through a small register port with byte enables and a one-cycle read latency.

Flags clear in three ways. Reading the receive word clears the full flag. Reading the status register, the top byte of the data register, or a vector register clears error flags. Writing a one to an error flag clears it. Each clear path is built so that a new event arriving in the same cycle is never dropped. A debug qualifier on the port turns any read into a pure observation with no side effects.

Top module: `spi_rx_status`

Register map, word addresses: 0 status, 1 data, 2 interrupt enable, 3 level select, 4 level-0 vector, 5 level-1 vector. The flag bit positions are: bit 0 bit error, bit 1 overrun, bit 2 receive full. Vector codes are: 0 none, 1 bit error, 2 overrun, 3 receive full.

## Requirements
- R1: A synchronous active-high reset clears all flags, the enable and level registers, and both interrupt lines.
- R2: A word pulse stores the word in the buffer and sets the full flag. A non-debug read of address 1 with any of byte enables 0 or 1 clears the full flag. If such a read coincides with a new word, the read returns the old word, the new word is stored, and the full flag stays set.
- R3: A word pulse that arrives while the full flag is set, and is not met by a clearing data read in the same cycle, sets the overrun flag and overwrites the buffer.
- R4: A pulse on the bit-error input sets the bit-error flag.
- R5: A write to address 0 with byte enable 0 clears the flags whose bits are 1 in data bits 0 (bit error) and 1 (overrun); data bit 2 is ignored. If the targeted flag was already set, the clear wins over a same-cycle set event. If the flag was clear, the set event wins.
- R6: A non-debug read of address 0 with byte enable 0, or of address 1 with byte enable 3 (the top byte), returns the flags before the read and clears both error flags. An error event in the same cycle survives.
- R7: Reads made with the debug qualifier high change no flag and no buffer contents.
- R8: Bit i of address 2 enables flag i, and bit i of address 3 routes it to line 1 (when 1) or line 0 (when 0). Each line is the registered OR of its enabled flags and changes on the same edge as the flags or registers it depends on.
- R9: Each vector register returns the code of the lowest-numbered enabled pending flag routed to its line, or 0 if there is none. A non-debug read (byte enable 0) clears the error flag it reports. It never clears the full flag.
- R10: Read data appears on the cycle after the read request. Bytes whose enable is low read as zero. Address 1 returns the buffer in the low bits and the flags in the top byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | ADDR_W | Register word address |
| reg_be | input | REG_W/8 | Byte enables |
| reg_wdata | input | REG_W | Write data |
| dbg_access | input | 1 | Marks the access as a debug observation |
| reg_rdata | output | REG_W | Registered read data |
| rx_word_valid | input | 1 | Shifter delivered a word |
| rx_word | input | DATA_W | Received word |
| rx_bit_err | input | 1 | Shifter detected a bit error |
| irq_lvl0 | output | 1 | Interrupt line 0 |
| irq_lvl1 | output | 1 | Interrupt line 1 |

## Verification
The properties assume that the shifter events are single-cycle pulses sampled on the clock edge. They also assume that read and write requests never occur in the same cycle and that addresses stay within the six defined registers. The stimulus drives every input just after the falling edge, never raises read and write together, and uses only mapped addresses. Races are created deliberately by putting an event pulse in the same cycle as a read or a write-one-to-clear.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_BERR = 0;
  localparam int SRC_OVR  = 1;
  localparam int SRC_FULL = 2;
  localparam int VEC_W    = $clog2(NSRC + 1);

  localparam int ADR_STAT = 0;
  localparam int ADR_DATA = 1;
  localparam int ADR_IEN  = 2;
  localparam int ADR_LVL  = 3;
  localparam int ADR_VEC0 = 4;
  localparam int ADR_VEC1 = 5;

  localparam int NLEVEL = 2;
endpackage

// File: rtl/spi_rxs_flag.sv
module spi_rxs_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rdclr_i,
  input  logic w1c_i,
  output logic d_o,
  output logic q_o
);
  // set beats a read clear; a write-one-to-clear on a flag already set beats set
  always_comb begin
    if (q_o && w1c_i) d_o = 1'b0;
    else              d_o = set_i | (q_o & ~rdclr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_o;
  end
endmodule

// File: rtl/spi_rxs_prio.sv
module spi_rxs_prio #(
  parameter int N = 3,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int REG_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W/8-1:0]   reg_be,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 dbg_access,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 rx_word_valid,
  input  logic [DATA_W-1:0]    rx_word,
  input  logic                 rx_bit_err,
  output logic                 irq_lvl0,
  output logic                 irq_lvl1
);
  localparam int NBYTE = REG_W / 8;

  logic sel_stat, sel_data, sel_ien, sel_lvl;
  logic [NLEVEL-1:0] sel_vec;
  logic rd_live, full_rdclr, err_rdclr, w1c_hit;
  logic [NSRC-1:0] flag_q, flag_d, set_v, rdclr_v, w1c_v, vec_rdclr;
  logic [NSRC-1:0] ien_q, ien_nxt, lvl_q, lvl_nxt;
  logic [VEC_W-1:0] vec_code [NLEVEL];
  logic [DATA_W-1:0] buf_q;
  logic [REG_W-1:0] rd_word, rd_mask;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:NSRC];

  // address decode
  always_comb begin
    sel_stat   = reg_addr == ADDR_W'(ADR_STAT);
    sel_data   = reg_addr == ADDR_W'(ADR_DATA);
    sel_ien    = reg_addr == ADDR_W'(ADR_IEN);
    sel_lvl    = reg_addr == ADDR_W'(ADR_LVL);
    sel_vec[0] = reg_addr == ADDR_W'(ADR_VEC0);
    sel_vec[1] = reg_addr == ADDR_W'(ADR_VEC1);
  end

  // side-effect qualifiers
  assign rd_live    = reg_rd & ~dbg_access;
  assign full_rdclr = rd_live & sel_data & (|reg_be[1:0]);
  assign err_rdclr  = rd_live & ((sel_stat & reg_be[0]) | (sel_data & reg_be[NBYTE-1]));
  assign w1c_hit    = reg_wr & sel_stat & reg_be[0];

  // vector encoders, one per interrupt level
  genvar lv;
  generate
    for (lv = 0; lv < NLEVEL; lv++) begin : g_level
      logic [NSRC-1:0] pend;
      assign pend = flag_q & ien_q & ((lv == 1) ? lvl_q : ~lvl_q);
      spi_rxs_prio #(.N(NSRC)) u_prio (
        .pend_i (pend),
        .code_o (vec_code[lv])
      );
    end
  endgenerate

  // a vector read clears only the error flag it reports
  always_comb begin
    vec_rdclr = '0;
    for (int s = 0; s < NSRC; s++) begin
      for (int l = 0; l < NLEVEL; l++) begin
        if (rd_live && reg_be[0] && sel_vec[l] && vec_code[l] == VEC_W'(s + 1) && s != SRC_FULL)
          vec_rdclr[s] = 1'b1;
      end
    end
  end

  // per-flag event routing
  always_comb begin
    set_v   = '0;
    rdclr_v = '0;
    w1c_v   = '0;
    set_v[SRC_BERR]   = rx_bit_err;
    set_v[SRC_OVR]    = rx_word_valid & flag_q[SRC_FULL] & ~full_rdclr;
    set_v[SRC_FULL]   = rx_word_valid;
    rdclr_v[SRC_BERR] = err_rdclr | vec_rdclr[SRC_BERR];
    rdclr_v[SRC_OVR]  = err_rdclr | vec_rdclr[SRC_OVR];
    rdclr_v[SRC_FULL] = full_rdclr;
    w1c_v[SRC_BERR]   = w1c_hit & reg_wdata[SRC_BERR];
    w1c_v[SRC_OVR]    = w1c_hit & reg_wdata[SRC_OVR];
  end

  genvar fi;
  generate
    for (fi = 0; fi < NSRC; fi++) begin : g_flag
      spi_rxs_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_v[fi]),
        .rdclr_i (rdclr_v[fi]),
        .w1c_i   (w1c_v[fi]),
        .d_o     (flag_d[fi]),
        .q_o     (flag_q[fi])
      );
    end
  endgenerate

  // enable and level registers
  assign ien_nxt = (reg_wr && sel_ien && reg_be[0]) ? reg_wdata[NSRC-1:0] : ien_q;
  assign lvl_nxt = (reg_wr && sel_lvl && reg_be[0]) ? reg_wdata[NSRC-1:0] : lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q    <= '0;
      lvl_q    <= '0;
      irq_lvl0 <= 1'b0;
      irq_lvl1 <= 1'b0;
    end else begin
      ien_q    <= ien_nxt;
      lvl_q    <= lvl_nxt;
      irq_lvl0 <= |(flag_d & ien_nxt & ~lvl_nxt);
      irq_lvl1 <= |(flag_d & ien_nxt & lvl_nxt);
    end
  end

  // receive buffer
  always_ff @(posedge clk) begin
    if (rst)                buf_q <= '0;
    else if (rx_word_valid) buf_q <= rx_word;
  end

  // read path
  always_comb begin
    rd_word = '0;
    if (sel_stat) rd_word[NSRC-1:0] = flag_q;
    if (sel_data) begin
      rd_word[DATA_W-1:0]  = buf_q;
      rd_word[REG_W-1 -: 8] = 8'(flag_q);
    end
    if (sel_ien)    rd_word[NSRC-1:0]  = ien_q;
    if (sel_lvl)    rd_word[NSRC-1:0]  = lvl_q;
    if (sel_vec[0]) rd_word[VEC_W-1:0] = vec_code[0];
    if (sel_vec[1]) rd_word[VEC_W-1:0] = vec_code[1];
  end

  genvar bi;
  generate
    for (bi = 0; bi < NBYTE; bi++) begin : g_mask
      assign rd_mask[bi*8 +: 8] = {8{reg_be[bi]}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word & rd_mask;
  end
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
  parameter int ADDR_W = 3,
  parameter int NBYTE  = 4,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NBYTE-1:0]  reg_be,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              dbg_access,
  input logic              rx_word_valid,
  input logic              rx_bit_err,
  input logic [2:0]        flags,
  input logic [2:0]        ien,
  input logic [2:0]        lvl,
  input logic              full_rdclr,
  input logic              irq_lvl0,
  input logic              irq_lvl1
);
  logic stat_w1c;
  assign stat_w1c = reg_wr && reg_addr == '0 && reg_be[0];

  assert_full_set_R2: assert property (@(posedge clk) disable iff (rst)
    rx_word_valid |=> flags[2]);

  assert_ovr_set_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_word_valid && flags[2] && !full_rdclr && !(stat_w1c && reg_wdata[1] && flags[1])) |=> flags[1]);

  assert_berr_set_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_bit_err && !(stat_w1c && reg_wdata[0] && flags[0])) |=> flags[0]);

  assert_w1c_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_w1c && reg_wdata[1] && flags[1]) |=> !flags[1]);

  assert_dbg_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && dbg_access && !reg_wr && !rx_word_valid && !rx_bit_err) |=> $stable(flags));

  assert_irq0_R8: assert property (@(posedge clk) disable iff (rst)
    irq_lvl0 == |(flags & ien & ~lvl));

  assert_irq1_R8: assert property (@(posedge clk) disable iff (rst)
    irq_lvl1 == |(flags & ien & lvl));
endmodule

bind spi_rx_status spi_rx_status_chk #(
  .ADDR_W (ADDR_W),
  .NBYTE  (REG_W / 8),
  .REG_W  (REG_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_rd        (reg_rd),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_be        (reg_be),
  .reg_wdata     (reg_wdata),
  .dbg_access    (dbg_access),
  .rx_word_valid (rx_word_valid),
  .rx_bit_err    (rx_bit_err),
  .flags         (flag_q),
  .ien           (ien_q),
  .lvl           (lvl_q),
  .full_rdclr    (full_rdclr),
  .irq_lvl0      (irq_lvl0),
  .irq_lvl1      (irq_lvl1)
);

// File: tb/tb_spi_rx_status.sv
module tb_spi_rx_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, dbg_access = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_word_valid = 1'b0, rx_bit_err = 1'b0;
  logic [15:0] rx_word = '0;
  logic        irq_lvl0, irq_lvl1;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int total = 0;
  int bad = 0;
  logic rd_d = 1'b0;
  logic arm_v = 1'b0, arm_b = 1'b0;
  logic [15:0] arm_w = '0;

  always #10 clk = ~clk;

  spi_rx_status dut (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .dbg_access(dbg_access), .reg_rdata(reg_rdata),
    .rx_word_valid(rx_word_valid), .rx_word(rx_word), .rx_bit_err(rx_bit_err),
    .irq_lvl0(irq_lvl0), .irq_lvl1(irq_lvl1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: read data shows up one cycle after the request
  always @(posedge clk) rd_d <= reg_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (sb_q.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, reg_rdata, e.exp);
      end
    end
  end

  task automatic arm(input logic v, input logic [15:0] w, input logic b);
    arm_v = v; arm_w = w; arm_b = b;
  endtask

  task automatic apply(input logic rd, input logic wr, input logic [2:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input logic dbg, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_be = be; reg_wdata = wd; dbg_access = dbg;
    rx_word_valid = arm_v; rx_word = arm_w; rx_bit_err = arm_b;
    arm_v = 1'b0; arm_b = 1'b0;
    if (rd) sb_q.push_back('{exp, tag});
  endtask

  task automatic idle();
    apply(1'b0, 1'b0, 3'd0, 4'h0, 32'h0, 1'b0, 32'h0, "");
  endtask

  task automatic rd(input logic [2:0] a, input logic [3:0] be, input logic dbg,
                    input logic [31:0] exp, input string tag);
    apply(1'b1, 1'b0, a, be, 32'h0, dbg, exp, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] wd);
    apply(1'b0, 1'b1, a, 4'h1, wd, 1'b0, 32'h0, "");
  endtask

  initial begin
    #(20 * 100000);
    chk("watchdog", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R1 reset state
    chk("R1 irq0", {31'b0, irq_lvl0}, 32'h0);
    chk("R1 irq1", {31'b0, irq_lvl1}, 32'h0);
    rd(3'd0, 4'hF, 1'b1, 32'h0, "R1 status");
    rd(3'd2, 4'hF, 1'b1, 32'h0, "R1 enable");

    // R2 arrival and clearing read
    arm(1'b1, 16'h1234, 1'b0); idle();
    rd(3'd0, 4'hF, 1'b1, 32'h4, "R2 full set");
    rd(3'd1, 4'h3, 1'b0, 32'h1234, "R2 data");
    rd(3'd0, 4'hF, 1'b1, 32'h0, "R2 full cleared");

    // R2 collision of read with arrival
    arm(1'b1, 16'h5555, 1'b0); idle();
    arm(1'b1, 16'hAAAA, 1'b0); rd(3'd1, 4'h3, 1'b0, 32'h5555, "R2 old word");
    rd(3'd0, 4'hF, 1'b1, 32'h4, "R2 R3 full kept no overrun");
    rd(3'd1, 4'h3, 1'b1, 32'hAAAA, "R2 new word");
    rd(3'd0, 4'hF, 1'b1, 32'h4, "R7 debug data read kept full");

    // R3 overrun
    arm(1'b1, 16'h0F0F, 1'b0); idle();
    rd(3'd0, 4'hF, 1'b1, 32'h6, "R3 overrun");
    rd(3'd1, 4'hF, 1'b1, 32'h06000F0F, "R10 R3 data word");

    // R5 clear of a set flag wins over set
    arm(1'b1, 16'h1111, 1'b0); wr(3'd0, 32'h2);
    rd(3'd0, 4'hF, 1'b1, 32'h4, "R5 w1c wins");
    rd(3'd1, 4'h3, 1'b1, 32'h1111, "R3 overwritten");

    // R4 R5 set wins over clear of a clear flag
    arm(1'b0, 16'h0, 1'b1); wr(3'd0, 32'h1);
    rd(3'd0, 4'hF, 1'b1, 32'h5, "R4 R5 set wins");
    wr(3'd0, 32'h4);
    rd(3'd0, 4'hF, 1'b1, 32'h5, "R5 bit2 ignored");
    wr(3'd0, 32'h1);
    rd(3'd0, 4'hF, 1'b1, 32'h4, "R5 clear berr");

    // R6 read clear and race
    arm(1'b0, 16'h0, 1'b1); idle();
    rd(3'd0, 4'h1, 1'b0, 32'h5, "R6 status read");
    rd(3'd0, 4'hF, 1'b1, 32'h4, "R6 cleared");
    arm(1'b0, 16'h0, 1'b1); rd(3'd0, 4'h1, 1'b0, 32'h4, "R6 race read");
    rd(3'd0, 4'hF, 1'b1, 32'h5, "R6 event survives");
    rd(3'd1, 4'h8, 1'b0, 32'h05000000, "R6 R10 top byte");
    rd(3'd0, 4'hF, 1'b1, 32'h4, "R6 top byte cleared");

    // R7 debug reads
    arm(1'b0, 16'h0, 1'b1); idle();
    rd(3'd0, 4'h1, 1'b1, 32'h5, "R7 first");
    rd(3'd0, 4'h1, 1'b1, 32'h5, "R7 second");

    // R8 R9 interrupts and vectors
    wr(3'd2, 32'h7); wr(3'd3, 32'h4); idle(); idle();
    chk("R8 irq0 on", {31'b0, irq_lvl0}, 32'h1);
    chk("R8 irq1 on", {31'b0, irq_lvl1}, 32'h1);
    rd(3'd4, 4'hF, 1'b1, 32'h1, "R9 vec0");
    rd(3'd5, 4'hF, 1'b1, 32'h3, "R9 vec1");
    rd(3'd4, 4'h1, 1'b0, 32'h1, "R9 vec0 live");
    idle();
    chk("R8 irq0 off", {31'b0, irq_lvl0}, 32'h0);
    chk("R8 irq1 held", {31'b0, irq_lvl1}, 32'h1);
    rd(3'd4, 4'hF, 1'b1, 32'h0, "R9 vec0 none");
    rd(3'd5, 4'h1, 1'b0, 32'h3, "R9 vec1 live");
    rd(3'd0, 4'hF, 1'b1, 32'h4, "R9 full not cleared");

    // R9 priority among pending errors
    arm(1'b1, 16'h2222, 1'b1); idle();
    rd(3'd4, 4'hF, 1'b1, 32'h1, "R9 lowest wins");
    wr(3'd0, 32'h1);
    rd(3'd4, 4'hF, 1'b1, 32'h2, "R9 next source");
    idle();
    chk("R8 irq0 overrun", {31'b0, irq_lvl0}, 32'h1);
    wr(3'd0, 32'h2);
    rd(3'd1, 4'h3, 1'b0, 32'h2222, "R2 data after overrun");
    rd(3'd0, 4'hF, 1'b1, 32'h0, "R2 all clear");
    idle();
    chk("R8 irq0 idle", {31'b0, irq_lvl0}, 32'h0);
    chk("R8 irq1 idle", {31'b0, irq_lvl1}, 32'h0);
    rd(3'd5, 4'hF, 1'b1, 32'h0, "R9 vec1 none");
    rd(3'd3, 4'hF, 1'b0, 32'h4, "R8 level readback");
    idle(); idle(); idle();
    chk("scoreboard drained", sb_q.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule